// File: doc/BRIEF.md
# Nth-Chance Clock Victim Finder

This block picks a frame to reclaim when a page must be brought in and no frame is free. A single hand sweeps a ring of frames. Each frame keeps a use bit, which any reference to that frame sets, and a small count of sweeps it has sat through without being referenced. A frame that was referenced since the hand last passed gets a fresh start. A frame that was not referenced is only taken after the hand has found it idle a set number of times.

A client raises `req` for one cycle while `busy` is low. The hand then examines one frame per cycle, updating that frame's use bit and count, until it settles on a victim. It returns the frame index on `victim` together with a single-cycle `done`. The chance threshold `THRESH` runs from 1 to 7. A threshold of 1 gives the plain second-chance sweep. Larger values follow least-recently-used order more closely, but searches take longer.

Top module: `nth_clock_victim`

## Requirements
- R1: After reset `busy` and `done` are low, `victim` is 0, the hand rests on frame 0, and every frame has its use bit clear and its count at 0.
- R2: A cycle with `ref_valid` high sets the use bit of frame `ref_frame`, whether or not a search is running.
- R3: When the hand examines a frame whose use bit is set, it clears the use bit, resets that frame's count to 0, does not select the frame, and moves on.
- R4: When the hand examines a frame whose use bit is clear, the frame's count rises by one. The frame is selected when the raised count equals `THRESH`; otherwise the hand moves on. With `THRESH` = 1 the first frame found with a clear use bit is selected.
- R5: While a search runs, the hand advances by exactly one frame per cycle and wraps from frame `NUM_FRAMES`-1 to 0. While idle it does not move. After a selection it rests one frame past the victim, and the next search starts there.
- R6: A reference to the frame under the hand in the same cycle that frame is examined takes priority. The frame is treated as used, is not selected, has its count reset to 0, and keeps its use bit set.
- R7: A request is accepted only when `busy` is low. `busy` goes high the cycle after acceptance and stays high until the cycle `done` is raised. A request made while `busy` is high has no effect.
- R8: `done` is high for exactly one cycle per accepted request. `victim` carries the chosen frame index while `done` is high and holds that value until the next selection.
- R9: The selected frame leaves the search with its use bit clear and its count at 0.
- R10: A search during which no reference arrives ends within (`THRESH`+1)·`NUM_FRAMES` examination cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_valid | input | 1 | Reference strobe for one frame |
| ref_frame | input | $clog2(NUM_FRAMES) | Index of the referenced frame |
| req | input | 1 | Request a victim search |
| busy | output | 1 | Search in progress; requests are ignored |
| done | output | 1 | One-cycle pulse: `victim` is valid |
| victim | output | $clog2(NUM_FRAMES) | Index of the chosen frame |

## Verification
The bench attacks these corner cases:
- A cold search over a ring where no frame has been referenced. It must make a full lap to age every frame and then return frame 0. A design that selected on the first clear bit would return frame 0 after a single step.
- A batch of back-to-back selections, followed by another full-lap search. A design that left counts stale on selected frames would settle on the wrong frame far too early.
- A reference aimed at the frame under the hand in its examination cycle. A design that gave the sweep priority would return that frame instead of its neighbour.
- A request raised in the middle of a search. A design that accepted it would produce a second `done`.
- A separate instance with threshold 1, which must pick the first unreferenced frame.

// File: rtl/nclk_pkg.sv
package nclk_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SPARE = 2'd1,
    ACT_AGE   = 2'd2,
    ACT_TAKE  = 2'd3
  } nclk_act_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } nclk_state_t;

endpackage

// File: rtl/nclk_rst_sync.sv
module nclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/nclk_frame_slot.sv
module nclk_frame_slot
  import nclk_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_hit,
  input  nclk_act_t        act,
  output logic             use_bit,
  output logic [CNT_W-1:0] cnt
);

  logic             use_q, use_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             slot_en;

  // a reference wins over clearing, except on selection (never issued on a hit)
  always_comb begin
    use_d = use_q;
    cnt_d = cnt_q;
    case (act)
      ACT_SPARE: begin
        use_d = ref_hit;
        cnt_d = '0;
      end
      ACT_AGE: begin
        use_d = use_q | ref_hit;
        cnt_d = cnt_q + 1'b1;
      end
      ACT_TAKE: begin
        use_d = 1'b0;
        cnt_d = '0;
      end
      default: begin
        use_d = use_q | ref_hit;
      end
    endcase
  end

  assign slot_en = ref_hit | (act != ACT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= 1'b0;
      cnt_q <= '0;
    end else if (slot_en) begin
      use_q <= use_d;
      cnt_q <= cnt_d;
    end
  end

  assign use_bit = use_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/nclk_hand_ctrl.sv
module nclk_hand_ctrl
  import nclk_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int CNT_W      = 3,
  parameter int THRESH     = 2,
  localparam int IW        = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             ref_valid,
  input  logic [IW-1:0]    ref_frame,
  input  logic             cur_use,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic [IW-1:0]    hand,
  output nclk_act_t        act_sel,
  output logic             busy,
  output logic             done,
  output logic [IW-1:0]    victim
);

  localparam logic [IW-1:0]  LAST  = IW'(NUM_FRAMES - 1);
  localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(THRESH);

  nclk_state_t     state_q, state_d;
  logic [IW-1:0]   hand_q, hand_d;
  logic [IW-1:0]   victim_q, victim_d;
  logic            done_q, done_d;
  logic [IW-1:0]   hand_nxt;
  logic [CNT_W:0]  cnt_inc;
  logic            ref_here;
  logic            hand_en;
  logic            victim_en;

  assign hand_nxt = (hand_q == LAST) ? '0 : hand_q + 1'b1;
  assign cnt_inc  = {1'b0, cur_cnt} + 1'b1;
  assign ref_here = ref_valid && (ref_frame == hand_q);

  always_comb begin
    state_d  = state_q;
    hand_d   = hand_q;
    victim_d = victim_q;
    done_d   = 1'b0;
    act_sel  = ACT_NONE;
    case (state_q)
      ST_IDLE: begin
        if (req) state_d = ST_SCAN;
      end
      ST_SCAN: begin
        hand_d = hand_nxt;
        if (ref_here || cur_use) begin
          act_sel = ACT_SPARE;
        end else if (cnt_inc >= LIMIT) begin
          act_sel  = ACT_TAKE;
          done_d   = 1'b1;
          victim_d = hand_q;
          state_d  = ST_IDLE;
        end else begin
          act_sel = ACT_AGE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign hand_en   = (state_q == ST_SCAN);
  assign victim_en = done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hand_q <= '0;
    else if (hand_en) hand_q <= hand_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         victim_q <= '0;
    else if (victim_en) victim_q <= victim_d;
  end

  assign hand   = hand_q;
  assign busy   = (state_q == ST_SCAN);
  assign done   = done_q;
  assign victim = victim_q;

endmodule

// File: rtl/nth_clock_victim.sv
module nth_clock_victim
  import nclk_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int CNT_W      = 3,
  parameter int THRESH     = 2,
  localparam int IW        = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_valid,
  input  logic [IW-1:0] ref_frame,
  input  logic          req,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] victim
);

  logic             rst_n_sync;
  logic [IW-1:0]    hand_w;
  nclk_act_t        act_sel;
  logic             use_vec [NUM_FRAMES];
  logic [CNT_W-1:0] cnt_arr [NUM_FRAMES];
  logic             cur_use;
  logic [CNT_W-1:0] cur_cnt;

  nclk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar gi = 0; gi < NUM_FRAMES; gi++) begin : g_slot
    logic      hit;
    nclk_act_t act;
    assign hit = ref_valid && (ref_frame == IW'(gi));
    assign act = (hand_w == IW'(gi)) ? act_sel : ACT_NONE;
    nclk_frame_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .ref_hit (hit),
      .act     (act),
      .use_bit (use_vec[gi]),
      .cnt     (cnt_arr[gi])
    );
  end

  assign cur_use = use_vec[hand_w];
  assign cur_cnt = cnt_arr[hand_w];

  nclk_hand_ctrl #(
    .NUM_FRAMES (NUM_FRAMES),
    .CNT_W      (CNT_W),
    .THRESH     (THRESH)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req       (req),
    .ref_valid (ref_valid),
    .ref_frame (ref_frame),
    .cur_use   (cur_use),
    .cur_cnt   (cur_cnt),
    .hand      (hand_w),
    .act_sel   (act_sel),
    .busy      (busy),
    .done      (done),
    .victim    (victim)
  );

endmodule

// File: rtl/nclk_checker.sv
module nclk_checker #(
  parameter int NUM_FRAMES = 16,
  parameter int THRESH     = 2,
  localparam int IW        = $clog2(NUM_FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_valid,
  input logic          busy,
  input logic          done,
  input logic [IW-1:0] victim,
  input logic [IW-1:0] hand
);

  localparam logic [IW-1:0] LAST  = IW'(NUM_FRAMES - 1);
  localparam int            BOUND = (THRESH + 1) * NUM_FRAMES;

  logic [15:0] scan_len;
  logic        clean;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_len <= '0;
      clean    <= 1'b1;
    end else if (!busy) begin
      scan_len <= '0;
      clean    <= 1'b1;
    end else begin
      scan_len <= scan_len + 1'b1;
      if (ref_valid) clean <= 1'b0;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_victim_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(victim));

  assert_hand_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand == (($past(hand) == LAST) ? '0 : $past(hand) + 1'b1)));

  assert_hand_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(hand));

  assert_rest_past_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hand == ((victim == LAST) ? '0 : victim + 1'b1)));

  assert_search_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clean) |-> (int'(scan_len) < BOUND));

endmodule

bind nth_clock_victim nclk_checker #(
  .NUM_FRAMES (NUM_FRAMES),
  .THRESH     (THRESH)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .ref_valid (ref_valid),
  .busy      (busy),
  .done      (done),
  .victim    (victim),
  .hand      (hand_w)
);

// File: tb/nth_clock_victim_tb_top.sv
module nth_clock_victim_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NF         = 16;
  localparam int TH         = 2;
  localparam int IW         = 4;

  logic          clk;
  logic          rst_n;
  logic          ref_valid, req;
  logic [IW-1:0] ref_frame;
  logic          busy, done;
  logic [IW-1:0] victim;

  logic          t1_ref_valid, t1_req;
  logic [IW-1:0] t1_ref_frame;
  logic          t1_busy, t1_done;
  logic [IW-1:0] t1_victim;

  int total_checks = 0;
  int bad_checks   = 0;
  bit model_on     = 0;
  bit finished     = 0;
  int cycles       = 0;

  nth_clock_victim #(.NUM_FRAMES(NF), .CNT_W(3), .THRESH(TH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .req(req), .busy(busy), .done(done), .victim(victim));

  nth_clock_victim #(.NUM_FRAMES(NF), .CNT_W(3), .THRESH(1)) dut_t1_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(t1_ref_valid), .ref_frame(t1_ref_frame),
    .req(t1_req), .busy(t1_busy), .done(t1_done), .victim(t1_victim));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model of the main instance
  int  m_use [NF];
  int  m_cnt [NF];
  int  m_hand;
  bit  m_scan;
  bit  m_done;
  int  m_victim;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_use[i]) begin m_use[i] = 0; m_cnt[i] = 0; end
      m_hand = 0; m_scan = 0; m_done = 0; m_victim = 0;
    end else begin
      m_done = 0;
      if (m_scan) begin
        int h;
        h = m_hand;
        m_hand = (m_hand + 1) % NF;
        if ((ref_valid && int'(ref_frame) == h) || m_use[h] != 0) begin
          m_use[h] = 0;
          m_cnt[h] = 0;
        end else if (m_cnt[h] + 1 >= TH) begin
          m_use[h] = 0;
          m_cnt[h] = 0;
          m_done = 1;
          m_victim = h;
          m_scan = 0;
        end else begin
          m_cnt[h] = m_cnt[h] + 1;
        end
      end else if (req) begin
        m_scan = 1;
      end
      if (ref_valid) m_use[int'(ref_frame)] = 1;
    end
  end

  always @(negedge clk) begin
    if (model_on && !finished) begin
      check(busy == m_scan, "R7 busy vs model", int'(busy), int'(m_scan));
      check(done == m_done, "R8 done vs model", int'(done), int'(m_done));
      check(int'(victim) == m_victim, "R4 victim vs model", int'(victim), m_victim);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total_checks++;
      bad_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  // one request; optional extra request pulse and reference at given cycles
  task automatic do_req(input bit use_t1, input int extra_at, input int ref_at,
                        input int ref_fr, output int lat, output int vic);
    int k;
    @(negedge clk);
    if (use_t1) t1_req = 1'b1; else req = 1'b1;
    k = 0;
    lat = -1;
    vic = -1;
    while (k < 400) begin
      @(negedge clk);
      k++;
      if ((use_t1 ? t1_done : done) == 1'b1) begin
        lat = k;
        vic = int'(use_t1 ? t1_victim : victim);
        if (use_t1) begin t1_req = 1'b0; t1_ref_valid = 1'b0; end
        else begin req = 1'b0; ref_valid = 1'b0; end
        break;
      end
      if (use_t1) begin
        t1_req       = (k == extra_at);
        t1_ref_valid = (k == ref_at);
        t1_ref_frame = IW'(ref_fr);
      end else begin
        req       = (k == extra_at);
        ref_valid = (k == ref_at);
        ref_frame = IW'(ref_fr);
      end
    end
  endtask

  task automatic touch(input bit use_t1, input int fr);
    @(negedge clk);
    if (use_t1) begin t1_ref_valid = 1'b1; t1_ref_frame = IW'(fr); end
    else begin ref_valid = 1'b1; ref_frame = IW'(fr); end
    @(negedge clk);
    if (use_t1) t1_ref_valid = 1'b0; else ref_valid = 1'b0;
  endtask

  initial begin
    int lat, vic;
    rst_n = 1'b0; req = 1'b0; ref_valid = 1'b0; ref_frame = '0;
    t1_req = 1'b0; t1_ref_valid = 1'b0; t1_ref_frame = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(victim == '0, "R1 victim after reset", int'(victim), 0);

    // R4 R10: cold ring needs one full lap of aging, then frame 0
    do_req(0, -1, -1, 0, lat, vic);
    check(vic == 0, "R4 cold victim", vic, 0);
    check(lat == 18, "R10 cold latency", lat, 18);

    // R5: next search starts one past the victim, frame 1 already aged once
    do_req(0, -1, -1, 0, lat, vic);
    check(vic == 1, "R5 resume past victim", vic, 1);
    check(lat == 2, "R5 resume latency", lat, 2);

    // R2 R3: referenced frames 2 and 3 are spared, frame 4 taken
    touch(0, 2);
    touch(0, 3);
    do_req(0, -1, -1, 0, lat, vic);
    check(vic == 4, "R3 spared referenced frames", vic, 4);
    check(lat == 4, "R2 R3 latency", lat, 4);

    // take frames 5..15 one after another
    for (int f = 5; f < NF; f++) begin
      do_req(0, -1, -1, 0, lat, vic);
      check(vic == f, "R4 aged frame taken", vic, f);
    end

    // R9 R7: counts of taken frames were cleared, so a full lap is needed again;
    // an extra request in mid search must be ignored
    do_req(0, 5, -1, 0, lat, vic);
    check(vic == 0, "R9 cleared counts force full lap", vic, 0);
    check(lat == 18, "R9 full lap latency", lat, 18);
    repeat (30) begin
      @(negedge clk);
      check(done == 1'b0, "R7 no done from ignored request", int'(done), 0);
      check(busy == 1'b0, "R7 stays idle", int'(busy), 0);
    end

    // R6: reference to the frame under the hand in its examination cycle
    do_req(0, -1, 1, 1, lat, vic);
    check(vic == 2, "R6 same-cycle reference wins", vic, 2);
    check(lat == 3, "R6 latency", lat, 3);

    // random traffic compared against the model every cycle (R2..R9)
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      ref_valid = ($urandom_range(3) == 0);
      ref_frame = IW'($urandom_range(NF - 1));
      req       = ($urandom_range(7) == 0);
    end
    @(negedge clk);
    req = 1'b0; ref_valid = 1'b0;
    repeat (200) @(negedge clk);

    // R4: threshold 1 instance behaves as plain second chance
    do_req(1, -1, -1, 0, lat, vic);
    check(vic == 0, "R4 thresh1 first clear frame", vic, 0);
    check(lat == 2, "R4 thresh1 latency", lat, 2);
    touch(1, 1);
    do_req(1, -1, -1, 0, lat, vic);
    check(vic == 2, "R3 thresh1 skips used frame", vic, 2);
    check(lat == 3, "R3 thresh1 latency", lat, 3);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule